// File: doc/BRIEF.md
# Fetch Address Watchpoint Unit

This block observes every instruction fetch address and raises a debug event when that address satisfies a programmable condition. The condition is built from two 32-bit compare values, called A and B. In the simplest mode each value acts on its own as an exact breakpoint. In the other three modes the two values work as a pair. In masked mode, B selects which address bits must agree with A. In the two range modes, A and B are the bounds of a window, and the event fires either inside that window or outside it. Each comparator can also require a particular value of the instruction-space bit that comes with the fetch.

A matching fetch sets sticky status bits. Software clears these bits by writing 1 to them. What happens next depends on the debug-enable input. When debug-enable is low, the event is only recorded, and it is flagged as imprecise. When debug-enable is high and no higher-priority exception is pending, the unit raises a one-cycle debug interrupt request and a one-cycle suppress signal for the faulting instruction, and it stores the fetch address in a save register. The compare logic is combinational. Every output is registered on the clock edge that samples the fetch.

Top module: `fwatch_unit`

## Requirements
- R1: After reset, all status bits, `dbg_irq` and `fetch_kill` are 0, `save_addr` is 0, and both comparators are disabled.
- R2: In exact mode (control mode field bits [7:6] = 0), comparator A matches when the fetch address equals A, and comparator B matches when the fetch address equals B. Each match sets only its own status bit.
- R3: In masked mode (mode 1), an event fires when (address AND B) equals (A AND B), and it sets both `hit_a` and `hit_b`.
- R4: In inside-range mode (mode 2), an event fires when A <= address < B, compared as unsigned values, and it sets both status bits.
- R5: In outside-range mode (mode 3), an event fires when address < A or address >= B, compared as unsigned values, and it sets both status bits.
- R6: Each comparator has a 2-bit qualifier. Comparator A uses control bits [3:2] and comparator B uses bits [5:4]. The codes are: 0 = address only, 1 = reserved (treated as address only), 2 = `ispace` must be 0, 3 = `ispace` must be 1.
- R7: Comparator A is enabled by control bit 0 and comparator B by control bit 1. A disabled comparator never matches. A paired mode fires only when both comparators are enabled and both qualifiers pass.
- R8: Status bits are set whatever the value of `dbg_en`. If `dbg_en` is 0 during an event, `imprecise` is also set and no interrupt is raised.
- R9: If `dbg_en` is 1 and `hi_pri_pend` is 0 during an event, `dbg_irq` and `fetch_kill` are 1 for exactly one cycle after the sampling edge, and `save_addr` takes the fetch address.
- R10: If `hi_pri_pend` is 1 during an event, the status bits are still set, but there is no interrupt and no suppress, and `save_addr` keeps its value.
- R11: Writing the status register (`wr_sel` = 3) clears each status bit whose data bit is 1. The bits are hit_a = bit 0, hit_b = bit 1, imprecise = bit 2. A hardware set in the same cycle wins over the clear.
- R12: A fetch with `fetch_valid` low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| ispace | input | 1 | Instruction-space bit of the fetch |
| dbg_en | input | 1 | Debug interrupts enabled |
| hi_pri_pend | input | 1 | A higher-priority exception is pending |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 = A, 1 = B, 2 = control, 3 = status clear |
| wr_data | input | 32 | Write data |
| hit_a | output | 1 | Sticky: comparator A event |
| hit_b | output | 1 | Sticky: comparator B event |
| imprecise | output | 1 | Sticky: event recorded while debug was disabled |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| fetch_kill | output | 1 | One-cycle suppress of the faulting instruction |
| save_addr | output | 32 | Address of the last instruction that took the interrupt |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a new match on the bit being cleared. The bench reaches it by driving the status write and a matching valid fetch on one falling edge. It also checks the opposite case, a clear with no new match. A second hard case is an event taken while a higher-priority exception is pending. To see it, `save_addr` is first loaded with a known value by a taken interrupt, so that the test can show the value is kept. The range boundaries are exercised at A, A-1, B-1 and B, and an address with bit 31 set checks that the comparison is unsigned.

// File: rtl/fwatch_pkg.sv
package fwatch_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT   = 2'd0,
    MODE_MASK    = 2'd1,
    MODE_INSIDE  = 2'd2,
    MODE_OUTSIDE = 2'd3
  } cmp_mode_e;

  localparam logic [1:0] SEL_CMPA = 2'd0;
  localparam logic [1:0] SEL_CMPB = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [1:0] QUAL_ANY   = 2'd0;
  localparam logic [1:0] QUAL_RSVD  = 2'd1;
  localparam logic [1:0] QUAL_IS_LO = 2'd2;
  localparam logic [1:0] QUAL_IS_HI = 2'd3;

  localparam int CTRL_W = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] qual_b;
    logic [1:0] qual_a;
    logic       en_b;
    logic       en_a;
  } ctrl_t;

endpackage

// File: rtl/fwatch_cfg.sv
module fwatch_cfg
  import fwatch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] cmp_a,
  output logic [AW-1:0] cmp_b,
  output ctrl_t         ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a <= '0;
      cmp_b <= '0;
      ctrl  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CMPA: cmp_a <= wr_data;
        SEL_CMPB: cmp_b <= wr_data;
        SEL_CTRL: ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/fwatch_match.sv
module fwatch_match
  import fwatch_pkg::*;
#(
  parameter int AW = 32,
  parameter int NCMP = 2
) (
  input  logic          ispace,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  input  ctrl_t         ctrl,
  output logic          match_a,
  output logic          match_b
);

  logic [NCMP-1:0] qual_ok;
  logic [NCMP-1:0] enables;
  logic [1:0]      quals [NCMP];

  assign enables  = {ctrl.en_b, ctrl.en_a};
  assign quals[0] = ctrl.qual_a;
  assign quals[1] = ctrl.qual_b;

  for (genvar i = 0; i < NCMP; i++) begin : g_qual
    always_comb begin
      case (quals[i])
        QUAL_IS_LO: qual_ok[i] = enables[i] & ~ispace;
        QUAL_IS_HI: qual_ok[i] = enables[i] &  ispace;
        default:    qual_ok[i] = enables[i];
      endcase
    end
  end

  logic pair_ok;
  logic ge_a, lt_b;
  logic pair_cond;

  assign pair_ok = &qual_ok;
  assign ge_a    = addr >= cmp_a;
  assign lt_b    = addr <  cmp_b;

  always_comb begin
    match_a   = 1'b0;
    match_b   = 1'b0;
    pair_cond = 1'b0;
    case (cmp_mode_e'(ctrl.mode))
      MODE_EXACT: begin
        match_a = qual_ok[0] & (addr == cmp_a);
        match_b = qual_ok[1] & (addr == cmp_b);
      end
      MODE_MASK:    pair_cond = (addr & cmp_b) == (cmp_a & cmp_b);
      MODE_INSIDE:  pair_cond = ge_a & lt_b;
      MODE_OUTSIDE: pair_cond = ~ge_a | ~lt_b;
      default:      pair_cond = 1'b0;
    endcase
    if (ctrl.mode != MODE_EXACT) begin
      match_a = pair_ok & pair_cond;
      match_b = pair_ok & pair_cond;
    end
  end

endmodule

// File: rtl/fwatch_status.sv
module fwatch_status
  import fwatch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          dbg_en,
  input  logic          hi_pri_pend,
  input  logic          match_a,
  input  logic          match_b,
  input  logic [2:0]    clr_mask,
  output logic          hit_a,
  output logic          hit_b,
  output logic          imprecise,
  output logic          dbg_irq,
  output logic          fetch_kill,
  output logic [AW-1:0] save_addr
);

  logic set_a, set_b, event_any, set_imp, take;

  assign set_a     = fetch_valid & match_a;
  assign set_b     = fetch_valid & match_b;
  assign event_any = set_a | set_b;
  assign set_imp   = event_any & ~dbg_en;
  assign take      = event_any & dbg_en & ~hi_pri_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_a      <= 1'b0;
      hit_b      <= 1'b0;
      imprecise  <= 1'b0;
      dbg_irq    <= 1'b0;
      fetch_kill <= 1'b0;
      save_addr  <= '0;
    end else begin
      hit_a      <= set_a   | (hit_a     & ~clr_mask[0]);
      hit_b      <= set_b   | (hit_b     & ~clr_mask[1]);
      imprecise  <= set_imp | (imprecise & ~clr_mask[2]);
      dbg_irq    <= take;
      fetch_kill <= take;
      if (take) save_addr <= fetch_addr;
    end
  end

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |-> ($past(fetch_valid) && $past(dbg_en) && !$past(hi_pri_pend)));

  p_save_addr_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_irq |-> (save_addr == $past(fetch_addr)));

  p_pending_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (hi_pri_pend && !dbg_irq) |=> (!dbg_irq && $stable(save_addr)));

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !clr_mask[0]) |=> hit_a);

  p_imprecise_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(imprecise) |-> !$past(dbg_en));

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!dbg_irq && !fetch_kill));

endmodule

// File: rtl/fwatch_unit.sv
module fwatch_unit
  import fwatch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ispace,
  input  logic          dbg_en,
  input  logic          hi_pri_pend,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          hit_a,
  output logic          hit_b,
  output logic          imprecise,
  output logic          dbg_irq,
  output logic          fetch_kill,
  output logic [AW-1:0] save_addr
);

  logic [AW-1:0] cmp_a, cmp_b;
  ctrl_t         ctrl;
  logic          match_a, match_b;
  logic [2:0]    clr_mask;

  assign clr_mask = (wr_en && wr_sel == SEL_STAT) ? wr_data[2:0] : 3'b000;

  fwatch_cfg #(.AW(AW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .ctrl    (ctrl)
  );

  fwatch_match #(.AW(AW), .NCMP(2)) u_match (
    .ispace  (ispace),
    .addr    (fetch_addr),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .ctrl    (ctrl),
    .match_a (match_a),
    .match_b (match_b)
  );

  fwatch_status #(.AW(AW)) u_status (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .dbg_en      (dbg_en),
    .hi_pri_pend (hi_pri_pend),
    .match_a     (match_a),
    .match_b     (match_b),
    .clr_mask    (clr_mask),
    .hit_a       (hit_a),
    .hit_b       (hit_b),
    .imprecise   (imprecise),
    .dbg_irq     (dbg_irq),
    .fetch_kill  (fetch_kill),
    .save_addr   (save_addr)
  );

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !ctrl.en_a && !ctrl.en_b) |-> (!match_a && !match_b));

  p_pair_both_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ctrl.mode != MODE_EXACT && (match_a || match_b)) |=> (hit_a && hit_b));

endmodule

// File: tb/fwatch_unit_bench.sv
`timescale 1ns/100ps
module fwatch_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        ispace = 1'b0;
  logic        dbg_en = 1'b0;
  logic        hi_pri_pend = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        hit_a, hit_b, imprecise, dbg_irq, fetch_kill;
  logic [31:0] save_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fwatch_unit u_fwatch_unit (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .ispace(ispace), .dbg_en(dbg_en), .hi_pri_pend(hi_pri_pend),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hit_a(hit_a), .hit_b(hit_b), .imprecise(imprecise), .dbg_irq(dbg_irq),
    .fetch_kill(fetch_kill), .save_addr(save_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic ea, input logic eb,
                           input logic ei, input logic eirq);
    chk({req, " hit_a"}, {31'd0, hit_a}, {31'd0, ea});
    chk({req, " hit_b"}, {31'd0, hit_b}, {31'd0, eb});
    chk({req, " imprecise"}, {31'd0, imprecise}, {31'd0, ei});
    chk({req, " irq"}, {31'd0, dbg_irq}, {31'd0, eirq});
    chk({req, " kill"}, {31'd0, fetch_kill}, {31'd0, eirq});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    wr(2'd3, 32'h7);
  endtask

  // control: mode[7:6] qual_b[5:4] qual_a[3:2] en_b[1] en_a[0]
  function automatic logic [31:0] ctl(input logic [1:0] mode, input logic [1:0] qb,
                                      input logic [1:0] qa, input logic eb, input logic ea);
    return {24'd0, mode, qb, qa, eb, ea};
  endfunction

  task automatic fetch(input logic [31:0] a, input logic is, input logic de,
                       input logic hp, input logic v = 1'b1);
    @(negedge clk);
    fetch_valid = v; fetch_addr = a; ispace = is; dbg_en = de; hi_pri_pend = hp;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R1 reset", 0, 0, 0, 0);
    chk("R1 save_addr", save_addr, 32'h0);
    fetch(32'h0, 0, 0, 0);
    chk_state("R1 disabled at reset", 0, 0, 0, 0);
  endtask

  task automatic t_exact();
    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'h0000_2000);
    wr(2'd2, ctl(2'd0, 2'd0, 2'd0, 1, 1));
    fetch(32'h0000_1000, 0, 0, 0);
    chk_state("R2/R8 exact A de=0", 1, 0, 1, 0);
    clear_all();
    fetch(32'h0000_2000, 0, 1, 0);
    chk_state("R2/R9 exact B de=1", 0, 1, 0, 1);
    chk("R9 save_addr", save_addr, 32'h0000_2000);
    @(negedge clk);
    chk_state("R9 one-cycle pulse", 0, 1, 0, 0);
    clear_all();
    fetch(32'h0000_1004, 0, 1, 0);
    chk_state("R2 exact miss", 0, 0, 0, 0);
  endtask

  task automatic t_invalid();
    fetch(32'h0000_1000, 0, 1, 0, 1'b0);
    chk_state("R12 invalid fetch", 0, 0, 0, 0);
    chk("R12 save kept", save_addr, 32'h0000_2000);
  endtask

  task automatic t_pending();
    fetch(32'h0000_1000, 0, 1, 1);
    chk_state("R10 pending", 1, 0, 0, 0);
    chk("R10 save kept", save_addr, 32'h0000_2000);
    clear_all();
  endtask

  task automatic t_mask();
    wr(2'd0, 32'h0000_1230);
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd2, ctl(2'd1, 2'd0, 2'd0, 1, 1));
    fetch(32'h0000_1234, 0, 0, 0);
    chk_state("R3 masked hit", 1, 1, 1, 0);
    clear_all();
    fetch(32'h0000_1334, 0, 0, 0);
    chk_state("R3 masked miss", 0, 0, 0, 0);
  endtask

  task automatic t_inside();
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_0200);
    wr(2'd2, ctl(2'd2, 2'd0, 2'd0, 1, 1));
    fetch(32'h0000_0100, 0, 0, 0);
    chk_state("R4 lower bound", 1, 1, 1, 0);
    clear_all();
    fetch(32'h0000_01FF, 0, 1, 0);
    chk_state("R4 top-1", 1, 1, 0, 1);
    chk("R4/R9 save", save_addr, 32'h0000_01FF);
    clear_all();
    fetch(32'h0000_0200, 0, 0, 0);
    chk_state("R4 upper excluded", 0, 0, 0, 0);
    fetch(32'h0000_00FF, 0, 0, 0);
    chk_state("R4 below", 0, 0, 0, 0);
  endtask

  task automatic t_outside();
    wr(2'd2, ctl(2'd3, 2'd0, 2'd0, 1, 1));
    fetch(32'h0000_00FF, 0, 0, 0);
    chk_state("R5 below A", 1, 1, 1, 0);
    clear_all();
    fetch(32'h0000_0200, 0, 0, 0);
    chk_state("R5 at B", 1, 1, 1, 0);
    clear_all();
    fetch(32'h8000_0000, 0, 0, 0);
    chk_state("R5 unsigned high", 1, 1, 1, 0);
    clear_all();
    fetch(32'h0000_0100, 0, 0, 0);
    chk_state("R5 at A", 0, 0, 0, 0);
    fetch(32'h0000_01FF, 0, 0, 0);
    chk_state("R5 inside", 0, 0, 0, 0);
  endtask

  task automatic t_qual();
    wr(2'd0, 32'h0000_3000);
    wr(2'd1, 32'h0000_4000);
    wr(2'd2, ctl(2'd0, 2'd3, 2'd2, 1, 1));
    fetch(32'h0000_3000, 1, 0, 0);
    chk_state("R6 A needs is=0", 0, 0, 0, 0);
    fetch(32'h0000_3000, 0, 0, 0);
    chk_state("R6 A is=0 hit", 1, 0, 1, 0);
    clear_all();
    fetch(32'h0000_4000, 0, 0, 0);
    chk_state("R6 B needs is=1", 0, 0, 0, 0);
    fetch(32'h0000_4000, 1, 0, 0);
    chk_state("R6 B is=1 hit", 0, 1, 1, 0);
    clear_all();
    wr(2'd2, ctl(2'd0, 2'd0, 2'd1, 1, 1));
    fetch(32'h0000_3000, 1, 0, 0);
    chk_state("R6 reserved code", 1, 0, 1, 0);
    clear_all();
  endtask

  task automatic t_disable();
    wr(2'd2, ctl(2'd0, 2'd0, 2'd0, 1, 0));
    fetch(32'h0000_3000, 0, 1, 0);
    chk_state("R7 A disabled", 0, 0, 0, 0);
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_0200);
    wr(2'd2, ctl(2'd2, 2'd0, 2'd0, 0, 1));
    fetch(32'h0000_0150, 0, 1, 0);
    chk_state("R7 pair needs both", 0, 0, 0, 0);
    wr(2'd2, ctl(2'd2, 2'd2, 2'd0, 1, 1));
    fetch(32'h0000_0150, 1, 0, 0);
    chk_state("R7 pair qual B fails", 0, 0, 0, 0);
  endtask

  task automatic t_w1c();
    wr(2'd0, 32'h0000_5000);
    wr(2'd1, 32'h0000_6000);
    wr(2'd2, ctl(2'd0, 2'd0, 2'd0, 1, 1));
    fetch(32'h0000_5000, 0, 0, 0);
    fetch(32'h0000_6000, 0, 0, 0);
    chk_state("R11 both set", 1, 1, 1, 0);
    wr(2'd3, 32'h1);
    chk_state("R11 clear A only", 0, 1, 1, 0);
    wr(2'd3, 32'h4);
    chk_state("R11 clear imprecise", 0, 1, 0, 0);
    @(negedge clk);
    chk_state("R11 sticky hold", 0, 1, 0, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h3;
    fetch_valid = 1'b1; fetch_addr = 32'h0000_5000; ispace = 0; dbg_en = 1; hi_pri_pend = 0;
    @(negedge clk);
    wr_en = 1'b0; fetch_valid = 1'b0;
    chk_state("R11 set beats clear", 1, 0, 0, 1);
    chk("R11 save", save_addr, 32'h0000_5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exact();
    t_invalid();
    t_pending();
    t_mask();
    t_inside();
    t_outside();
    t_qual();
    t_disable();
    t_w1c();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule